// File: doc/BRIEF.md
# DLL Bring-Up Sequencer

This block brings the delay-locked loops of a DDR PHY out of reset in a fixed, timed order. The PHY has one master DLL on the command and clock path and one DLL for each data byte lane. For every DLL the sequencer drives a phase setting, an active-low reset and a disable control. It walks each DLL through three timed phases. First it loads the phase, disables the DLL and holds it in reset. Next it clears the disable but keeps the reset asserted. Last it releases the reset.

A single start pulse latches a 32-bit configuration word and a bus-width flag. The master DLL runs all three phases to completion. Only after that do the active byte-lane DLLs run the same three phases. All active lanes move through each phase at the same time and share one wait. Waits are counted in pulses of an external microsecond strobe, so the timing does not depend on the clock frequency. When the last wait ends, the block raises `done_o` and holds it there until the next accepted start.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0. Every DLL has disable = 1, reset_n = 0 and phase = 0.
- R2: An accepted start latches the inputs. In that same cycle the master phase becomes configuration bits [21:16], the master disable goes to 1 and the master reset_n goes to 0. This state lasts for SETUP_US tick pulses (default 2).
- R3: In the second phase the master disable is 0 and reset_n stays 0. This phase lasts for RELEASE_US tick pulses (default 22).
- R4: In the third phase the master disable is 0 and reset_n is 1. This phase lasts for LOCK_US tick pulses (default 22).
- R5: No byte-lane output changes until the master has finished its third phase. While the lanes are sequencing, the master holds disable = 0 and reset_n = 1.
- R6: With `wide_bus_i` = 1, all four lanes are sequenced. With `wide_bus_i` = 0, only lanes 0 and 1 are sequenced, and lanes 2 and 3 keep their previous outputs.
- R7: Lane k (counting from 0) takes configuration bits [4k+3:4k] as its phase. This field sits at bits [4k+3:4k] of `lane_phase_o`.
- R8: The active lanes go through the same three phases as the master (disable/reset_n of 1/0, then 0/0, then 0/1), all changing in the same cycle. Each phase is followed by one shared wait of 2, 22 and 22 ticks.
- R9: A start pulse while `busy_o` is 1 is ignored. `done_o` rises in the cycle after the final tick, stays 1 until the next accepted start, and is never 1 while busy.
- R10: While busy, no output changes in a cycle that has no tick pulse.
- R11: Changes to `cfg_word_i` or `wide_bus_i` after the start pulse have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cfg_word_i | input | 32 | Packed phase configuration |
| wide_bus_i | input | 1 | 1 = 32-bit bus (four lanes), 0 = two lanes |
| us_tick_i | input | 1 | One-cycle microsecond strobe |
| mst_phase_o | output | 6 | Master DLL phase |
| mst_rst_n_o | output | 1 | Master DLL reset, active low |
| mst_dis_o | output | 1 | Master DLL disable |
| lane_phase_o | output | 16 | Lane phases, 4 bits per lane, lane 0 in the low bits |
| lane_rst_n_o | output | 4 | Lane DLL resets, active low |
| lane_dis_o | output | 4 | Lane DLL disables |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete |

## Verification
The bench runs a behavioural model of the phase timing and compares against it on every clock. It varies the tick spacing, pauses the tick strobe in the middle of a run, and applies a narrow-bus run after a wide one.

It looks for these faults:
- An off-by-one wait count. This shifts a phase edge by one tick and the bench sees it on the next clock.
- Skipping the middle phase. This makes reset_n rise in the same cycle as the disable falls.
- Sequencing the upper lanes on a narrow bus. This disturbs lane outputs that should hold their old values.
- Re-reading the configuration after start, or restarting on a start pulse that arrives while busy. Either one makes the final lane phases or the done timing disagree with the model.

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq #(
  parameter int LANES      = 4,
  parameter int LANE_PH_W  = 4,
  parameter int MST_PH_W   = 6,
  parameter int MST_PH_LSB = 16,
  parameter int CFG_W      = 32,
  parameter int SETUP_US   = 2,
  parameter int RELEASE_US = 22,
  parameter int LOCK_US    = 22
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [CFG_W-1:0]               cfg_word_i,
  input  logic                           wide_bus_i,
  input  logic                           us_tick_i,
  output logic [MST_PH_W-1:0]            mst_phase_o,
  output logic                           mst_rst_n_o,
  output logic                           mst_dis_o,
  output logic [LANES*LANE_PH_W-1:0]     lane_phase_o,
  output logic [LANES-1:0]               lane_rst_n_o,
  output logic [LANES-1:0]               lane_dis_o,
  output logic                           busy_o,
  output logic                           done_o
);
  localparam int NARROW = LANES / 2;
  localparam int MAXW0  = (SETUP_US > RELEASE_US) ? SETUP_US : RELEASE_US;
  localparam int MAXW   = (MAXW0 > LOCK_US) ? MAXW0 : LOCK_US;
  localparam int CNT_W  = $clog2(MAXW + 1);

  typedef enum logic [2:0] {S_IDLE, S_M1, S_M2, S_M3, S_L1, S_L2, S_L3} st_t;

  st_t               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              wide_q;
  int                wait_len;
  int                act_n;
  logic              last_tick;

  always_comb begin
    case (st_q)
      S_M1, S_L1: wait_len = SETUP_US;
      S_M2, S_L2: wait_len = RELEASE_US;
      default:    wait_len = LOCK_US;
    endcase
  end

  assign act_n     = wide_q ? LANES : NARROW;
  assign last_tick = us_tick_i && (int'(cnt_q) == wait_len - 1);
  assign busy_o    = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      cnt_q        <= '0;
      cfg_q        <= '0;
      wide_q       <= 1'b0;
      done_o       <= 1'b0;
      mst_phase_o  <= '0;
      mst_dis_o    <= 1'b1;
      mst_rst_n_o  <= 1'b0;
      lane_phase_o <= '0;
      lane_dis_o   <= '1;
      lane_rst_n_o <= '0;
    end else if (st_q == S_IDLE) begin
      if (start_i) begin
        st_q        <= S_M1;
        cnt_q       <= '0;
        cfg_q       <= cfg_word_i;
        wide_q      <= wide_bus_i;
        done_o      <= 1'b0;
        mst_phase_o <= cfg_word_i[MST_PH_LSB +: MST_PH_W];
        mst_dis_o   <= 1'b1;
        mst_rst_n_o <= 1'b0;
      end
    end else if (us_tick_i) begin
      if (last_tick) begin
        cnt_q <= '0;
        case (st_q)
          S_M1: begin st_q <= S_M2; mst_dis_o <= 1'b0; mst_rst_n_o <= 1'b0; end
          S_M2: begin st_q <= S_M3; mst_rst_n_o <= 1'b1; end
          S_M3: begin
            st_q <= S_L1;
            for (int i = 0; i < LANES; i++) begin
              if (i < act_n) begin
                lane_phase_o[i*LANE_PH_W +: LANE_PH_W] <= cfg_q[i*LANE_PH_W +: LANE_PH_W];
                lane_dis_o[i]   <= 1'b1;
                lane_rst_n_o[i] <= 1'b0;
              end
            end
          end
          S_L1: begin
            st_q <= S_L2;
            for (int i = 0; i < LANES; i++) begin
              if (i < act_n) begin
                lane_dis_o[i]   <= 1'b0;
                lane_rst_n_o[i] <= 1'b0;
              end
            end
          end
          S_L2: begin
            st_q <= S_L3;
            for (int i = 0; i < LANES; i++) begin
              if (i < act_n) lane_rst_n_o[i] <= 1'b1;
            end
          end
          default: begin st_q <= S_IDLE; done_o <= 1'b1; end
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  rst_after_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_rst_n_o) |-> $past(!mst_dis_o));

  // R5
  lanes_after_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lane_dis_o) || !$stable(lane_rst_n_o)) |-> (mst_rst_n_o && !mst_dis_o));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !us_tick_i) |=> ($stable(mst_dis_o) && $stable(mst_rst_n_o) &&
                                $stable(lane_dis_o) && $stable(lane_rst_n_o)));

  // R4
  no_dis_while_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mst_dis_o && mst_rst_n_o));
endmodule

// File: tb/dll_bringup_seq_tb_top.sv
module dll_bringup_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] cfg_word_i = '0;
  logic wide_bus_i = 1'b0;
  logic us_tick_i = 1'b0;
  logic [5:0] mst_phase_o;
  logic mst_rst_n_o, mst_dis_o, busy_o, done_o;
  logic [15:0] lane_phase_o;
  logic [3:0] lane_rst_n_o, lane_dis_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_bringup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_word_i(cfg_word_i),
    .wide_bus_i(wide_bus_i), .us_tick_i(us_tick_i), .mst_phase_o(mst_phase_o),
    .mst_rst_n_o(mst_rst_n_o), .mst_dis_o(mst_dis_o), .lane_phase_o(lane_phase_o),
    .lane_rst_n_o(lane_rst_n_o), .lane_dis_o(lane_dis_o), .busy_o(busy_o), .done_o(done_o));

  int checks = 0, fails = 0, cycles = 0, gap = 0, gcnt = 0;
  bit reported = 0;

  // behavioural reference
  int m_ph = 0, m_cnt = 0, m_act = 2;
  logic [31:0] m_cfg = '0;
  logic [5:0] m_mph = '0;
  logic m_mdis = 1, m_mrst = 0, m_done = 0;
  logic [3:0] m_lph [4];
  logic m_ldis [4], m_lrst [4];

  function automatic int dur(int p);
    return (p == 1 || p == 4) ? 2 : 22;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_done = 0; m_mph = '0; m_mdis = 1; m_mrst = 0;
      for (int i = 0; i < 4; i++) begin m_lph[i] = '0; m_ldis[i] = 1; m_lrst[i] = 0; end
    end else if (m_ph == 0) begin
      if (start_i) begin
        m_ph = 1; m_cnt = 0; m_cfg = cfg_word_i; m_act = wide_bus_i ? 4 : 2;
        m_done = 0; m_mph = cfg_word_i[21:16]; m_mdis = 1; m_mrst = 0;
      end
    end else if (us_tick_i) begin
      m_cnt++;
      if (m_cnt == dur(m_ph)) begin
        m_cnt = 0;
        m_ph++;
        if (m_ph == 2) begin m_mdis = 0; m_mrst = 0; end
        else if (m_ph == 3) m_mrst = 1;
        else if (m_ph == 7) begin m_ph = 0; m_done = 1; end
        else begin
          for (int i = 0; i < m_act; i++) begin
            if (m_ph == 4) begin m_lph[i] = m_cfg[4*i +: 4]; m_ldis[i] = 1; m_lrst[i] = 0; end
            else if (m_ph == 5) begin m_ldis[i] = 0; m_lrst[i] = 0; end
            else m_lrst[i] = 1;
          end
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mtag();
    case (m_ph)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6: return "R5";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 busy", {31'b0, busy_o}, {31'b0, m_ph != 0});
      chk("R9 done", {31'b0, done_o}, {31'b0, m_done});
      chk({mtag(), " master"}, {24'b0, mst_phase_o, mst_dis_o, mst_rst_n_o}, {24'b0, m_mph, m_mdis, m_mrst});
      for (int i = 0; i < 4; i++) begin
        if (i >= m_act && m_ph != 0) begin
          chk("R6 idle lane", {26'b0, lane_phase_o[4*i +: 4], lane_dis_o[i], lane_rst_n_o[i]},
              {26'b0, m_lph[i], m_ldis[i], m_lrst[i]});
        end else begin
          chk("R7 lane phase", {28'b0, lane_phase_o[4*i +: 4]}, {28'b0, m_lph[i]});
          chk("R8 lane ctrl", {30'b0, lane_dis_o[i], lane_rst_n_o[i]}, {30'b0, m_ldis[i], m_lrst[i]});
        end
      end
    end
  end

  always @(negedge clk) begin
    if (gap > 0) begin
      if (gcnt >= gap - 1) begin us_tick_i = 1; gcnt = 0; end
      else begin us_tick_i = 0; gcnt++; end
    end else us_tick_i = 0;
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  task automatic pulse_start(logic [31:0] cfg, logic wide);
    @(negedge clk);
    cfg_word_i = cfg; wide_bus_i = wide; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy/done", {30'b0, busy_o, done_o}, 32'h0);
    chk("R1 master", {24'b0, mst_phase_o, mst_dis_o, mst_rst_n_o}, {24'b0, 6'h0, 1'b1, 1'b0});
    rst_n = 1;
    @(negedge clk);
    chk("R1 lanes", {8'b0, lane_phase_o, lane_dis_o, lane_rst_n_o}, {8'b0, 16'h0, 4'hF, 4'h0});

    // wide bus, tick every clock
    gap = 1;
    pulse_start(32'hA5C3_9E71, 1'b1);
    wait_done();
    chk("R7 wide phases", {16'b0, lane_phase_o}, 32'h9E71);
    chk("R2 master phase", {26'b0, mst_phase_o}, 32'h03);
    repeat (10) @(negedge clk);
    chk("R9 done holds", {31'b0, done_o}, 32'h1);

    // narrow bus, sparse ticks, upper lanes held
    gap = 3;
    pulse_start(32'h0012_3456, 1'b0);
    wait_done();
    chk("R6 narrow phases", {16'b0, lane_phase_o}, 32'h9E56);

    // R10 tick pause, R9 start while busy, R11 input change
    gap = 2;
    pulse_start(32'h003F_C0DE, 1'b1);
    repeat (40) @(negedge clk);
    gap = 0;
    repeat (2) @(negedge clk);
    snap = {10'b0, mst_dis_o, mst_rst_n_o, lane_dis_o, lane_rst_n_o, lane_phase_o[11:0]};
    pulse_start(32'hFFFF_FFFF, 1'b0);
    cfg_word_i = 32'h1111_1111;
    repeat (50) @(negedge clk);
    chk("R10 paused", {10'b0, mst_dis_o, mst_rst_n_o, lane_dis_o, lane_rst_n_o, lane_phase_o[11:0]}, snap);
    chk("R10 still busy", {31'b0, busy_o}, 32'h1);
    gap = 1;
    wait_done();
    chk("R11 latched phases", {16'b0, lane_phase_o}, 32'hC0DE);
    chk("R11 master phase", {26'b0, mst_phase_o}, 32'h3F);
    repeat (5) @(negedge clk);
    report();
  end
endmodule